// File: doc/BRIEF.md
# Run-Length Sample Byte Serializer

This block turns stored 32-bit logic-analyzer samples into a byte stream for a slow host link. After a start pulse it reads the sample store from the most recent entry backwards. Each sample is emitted only as the bytes of its enabled 8-bit channel groups, lowest group first. The capture configuration latched at start sets which groups are skipped and whether run-length compression is applied.

With compression on, consecutive samples that match on all enabled groups are merged. A run is sent as a count word followed by one value word. The receiver tells the two apart by the most significant bit of the last byte of each word: set for a count, clear for a value. Bytes leave on a valid/ready port. Transmission stops when the programmed number of samples has been read or when the programmed number of words has been sent, whichever comes first. A one-cycle done pulse ends every capture.

Top module: `rle_byte_serializer`

## Requirements
- R1: After reset, `ob_valid` and `done` are low until a start pulse is accepted.
- R2: Bit 2+k of `cfg_flags` (k = 0..3), when 1, removes sample bits 8k+7:8k from the stream. Each word is sent as the bytes of its enabled groups only, in increasing group order.
- R3: Samples are read at `newest_addr`, then `newest_addr`-1 and so on, wrapping modulo the store depth, for `sample_cnt` samples. `rd_data` is taken one cycle after `rd_addr`.
- R4: With `cfg_flags` bit 0 clear, every word is a sample whose transmitted bytes are unmodified, including bit 7 of every byte.
- R5: With `cfg_flags` bit 0 set, a run of r+1 consecutive samples (r > 0) that are equal on the enabled groups is sent as a count word and then one value word. The count word carries r packed least-significant byte first into the transmitted bytes, with bit 7 of its last byte set. A run of one sample sends only the value word.
- R6: In run-length mode, bit 7 of the last transmitted byte of every value word is forced to 0.
- R7: A count never exceeds the smaller of `RUN_MAX` and 2^(8n-1)-1, where n is the number of enabled groups. A longer run is split into several count/value pairs.
- R8: No more than `word_limit` words (counts and values together) are sent. The stream may end after a count word.
- R9: While `ob_valid` is high and `ob_ready` is low, `ob_valid` stays high and `ob_data` holds. A byte moves on each cycle in which both are high.
- R10: `done` is high for exactly one cycle after the last byte of a capture. A start pulse while a capture is in progress is ignored.
- R11: With all four groups disabled, or `sample_cnt` or `word_limit` equal to zero, no byte is sent and `done` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a capture when idle; latches configuration |
| cfg_flags | input | 8 | Bit 0 run-length enable, bits 5:2 group disables |
| newest_addr | input | AW | Address of the most recent sample |
| sample_cnt | input | AW+1 | Number of samples to read |
| word_limit | input | WW | Maximum number of words to send |
| rd_addr | output | AW | Sample store read address |
| rd_data | input | 32 | Sample store data, one cycle after the address |
| ob_valid | output | 1 | Output byte valid |
| ob_data | output | 8 | Output byte |
| ob_ready | input | 1 | Downstream accepts the byte |
| done | output | 1 | One-cycle end-of-capture pulse |

## Verification
The read data is registered in the bench one cycle after `rd_addr`, which matches the store latency the block assumes. Each sample therefore costs at least two cycles before its first byte is presented, and the block then holds that byte until a handshake. The bench drives inputs 5 ns after the rising edge and samples every port on the falling edge. Each byte is recorded in the half cycle before the edge that moves it, and `done` is counted in the half cycle before the block returns to idle. Each scenario waits for the done pulse and then a few more cycles, so that a stray extra byte or a second pulse is also caught.

// File: rtl/rle_byte_serializer.sv
module rle_byte_serializer #(
  parameter int          AW      = 4,
  parameter int          WW      = 16,
  parameter logic [31:0] RUN_MAX = 32'h7FFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    cfg_flags,
  input  logic [AW-1:0] newest_addr,
  input  logic [AW:0]   sample_cnt,
  input  logic [WW-1:0] word_limit,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          ob_valid,
  output logic [7:0]    ob_data,
  input  logic          ob_ready,
  output logic          done
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CMP, S_CNT, S_VAL, S_FIN} st_t;

  st_t           st;
  logic [3:0]    en_q;
  logic          rle_q;
  logic [AW-1:0] addr;
  logic [AW:0]   rem;
  logic [WW-1:0] words, limit_q;
  logic [31:0]   val, run;
  logic          have;
  logic [1:0]    gidx, bk;

  logic [2:0]  n_en;
  logic [1:0]  first_g, next_g;
  logic [5:0]  sh;
  logic [31:0] cap_n, cap, mask;
  logic        eq, last_b, fire, word_end, limit_hit;
  logic [7:0]  raw;

  always_comb begin
    n_en    = '0;
    first_g = '0;
    next_g  = gidx;
    for (int k = 3; k >= 0; k--) begin
      n_en = n_en + 3'(en_q[k]);
      if (en_q[k]) first_g = 2'(k);
      if (en_q[k] && k > int'(gidx)) next_g = 2'(k);
    end
  end

  assign sh     = {n_en, 3'b000} - 6'd1;
  assign cap_n  = (n_en == 3'd0) ? 32'd0 : ((32'd1 << sh) - 32'd1);
  assign cap    = (cap_n < RUN_MAX) ? cap_n : RUN_MAX;
  assign mask   = {{8{en_q[3]}}, {8{en_q[2]}}, {8{en_q[1]}}, {8{en_q[0]}}};
  assign eq     = (rd_data & mask) == (val & mask);

  assign rd_addr   = addr;
  assign ob_valid  = (st == S_CNT) || (st == S_VAL);
  assign fire      = ob_valid && ob_ready;
  assign last_b    = ({1'b0, bk} == n_en - 3'd1);
  assign word_end  = fire && last_b;
  assign limit_hit = (words + WW'(1)) == limit_q;
  assign done      = (st == S_FIN);

  assign raw = (st == S_CNT) ? run[{bk, 3'b000} +: 8] : val[{gidx, 3'b000} +: 8];

  always_comb begin
    ob_data = raw;
    if (rle_q && last_b) ob_data[7] = (st == S_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      en_q    <= '0;
      rle_q   <= 1'b0;
      addr    <= '0;
      rem     <= '0;
      words   <= '0;
      limit_q <= '0;
      val     <= '0;
      run     <= '0;
      have    <= 1'b0;
      gidx    <= '0;
      bk      <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          en_q    <= ~cfg_flags[5:2];
          rle_q   <= cfg_flags[0];
          addr    <= newest_addr;
          rem     <= sample_cnt;
          limit_q <= word_limit;
          words   <= '0;
          have    <= 1'b0;
          run     <= '0;
          bk      <= '0;
          if (cfg_flags[5:2] == 4'hF || sample_cnt == '0 || word_limit == '0)
            st <= S_FIN;
          else
            st <= S_RD;
        end
        S_RD: st <= S_CMP;
        S_CMP: begin
          if (!have) begin
            val  <= rd_data;
            have <= 1'b1;
            run  <= '0;
            addr <= addr - AW'(1);
            rem  <= rem - (AW+1)'(1);
            gidx <= first_g;
            bk   <= '0;
            st   <= (!rle_q || rem == (AW+1)'(1)) ? S_VAL : S_RD;
          end else if (eq && run < cap) begin
            run  <= run + 32'd1;
            addr <= addr - AW'(1);
            rem  <= rem - (AW+1)'(1);
            st   <= (rem == (AW+1)'(1)) ? S_CNT : S_RD;
          end else begin
            st <= (run != '0) ? S_CNT : S_VAL;
          end
        end
        S_CNT: if (fire) begin
          if (last_b) begin
            words <= words + WW'(1);
            bk    <= '0;
            gidx  <= first_g;
            st    <= limit_hit ? S_FIN : S_VAL;
          end else begin
            bk   <= bk + 2'd1;
            gidx <= next_g;
          end
        end
        S_VAL: if (fire) begin
          if (last_b) begin
            words <= words + WW'(1);
            bk    <= '0;
            gidx  <= first_g;
            have  <= 1'b0;
            run   <= '0;
            st    <= (limit_hit || rem == '0) ? S_FIN : S_RD;
          end else begin
            bk   <= bk + 2'd1;
            gidx <= next_g;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, word_end, cfg_flags[7:6], cfg_flags[1]};

endmodule

module rle_byte_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ob_valid,
  input logic       ob_ready,
  input logic [7:0] ob_data,
  input logic       done
);

  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && !ob_ready |=> ob_valid);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && !ob_ready |=> $stable(ob_data));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ob_valid);

endmodule

bind rle_byte_serializer rle_byte_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ob_valid(ob_valid), .ob_ready(ob_ready),
  .ob_data(ob_data), .done(done)
);

// File: tb/rle_byte_serializer_bench.sv
`timescale 1ns/1ps
module rle_byte_serializer_bench;

  localparam logic [31:0] RMAX = 32'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  flags = '0;
  logic [3:0]  newest = '0;
  logic [4:0]  scnt = '0;
  logic [15:0] wlim = '0;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data = '0;
  logic        ob_valid;
  logic [7:0]  ob_data;
  logic        ob_ready = 1'b0;
  logic        done;

  rle_byte_serializer #(.AW(4), .WW(16), .RUN_MAX(RMAX)) u_rle_byte_serializer (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_flags(flags),
    .newest_addr(newest), .sample_cnt(scnt), .word_limit(wlim),
    .rd_addr(rd_addr), .rd_data(rd_data), .ob_valid(ob_valid),
    .ob_data(ob_data), .ob_ready(ob_ready), .done(done)
  );

  always #10 clk = ~clk;

  logic [31:0] mem [16];
  always @(posedge clk) rd_data <= mem[rd_addr];

  int checks = 0, fails = 0;
  int ng = 0, ndone = 0, holds = 0, hold_bad = 0;
  logic [7:0] got [1024];
  logic hold_pend = 1'b0;
  logic [7:0] hold_d = '0;
  int rmode = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(posedge clk) begin
    #5;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst_n) ob_ready = (rmode == 0) ? 1'b1 : lfsr[0];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        holds++;
        if (!ob_valid || ob_data != hold_d) hold_bad++;
      end
      hold_pend = ob_valid && !ob_ready;
      hold_d = ob_data;
      if (ob_valid && ob_ready) begin
        got[ng % 1024] = ob_data;
        ng++;
      end
      if (done) ndone++;
    end
  end

  logic [7:0] expb [1024];
  int nexp;

  task automatic model(input logic [7:0] f, input logic [3:0] nw, input int c, input int l);
    logic [3:0] en;
    logic [31:0] mk, v, capn, cap, r;
    int n, lastg, i, w;
    logic [7:0] b;
    en = ~f[5:2];
    n = 0; lastg = 0;
    for (int g = 0; g < 4; g++) if (en[g]) begin n++; lastg = g; end
    mk = {{8{en[3]}}, {8{en[2]}}, {8{en[1]}}, {8{en[0]}}};
    capn = (n == 0) ? 0 : ((32'd1 << (8*n-1)) - 1);
    cap = (capn < RMAX) ? capn : RMAX;
    nexp = 0; i = 0; w = 0;
    if (n == 0 || c == 0 || l == 0) return;
    while (i < c && w < l) begin
      v = mem[4'(int'(nw) - i)];
      i++;
      r = 0;
      if (f[0]) begin
        while (i < c && (mem[4'(int'(nw) - i)] & mk) == (v & mk) && r < cap) begin
          r++; i++;
        end
      end
      if (r > 0) begin
        for (int k = 0; k < n; k++) begin
          b = r[8*k +: 8];
          if (k == n-1) b[7] = 1'b1;
          expb[nexp++] = b;
        end
        w++;
        if (w >= l) break;
      end
      for (int g = 0; g < 4; g++) if (en[g]) begin
        b = v[8*g +: 8];
        if (f[0] && g == lastg) b[7] = 1'b0;
        expb[nexp++] = b;
      end
      w++;
    end
  endtask

  task automatic check_stream(input int base, input string tag);
    int cnt;
    checks++;
    cnt = ng - base;
    if (cnt != nexp) begin
      fails++;
      $display("FAIL %s byte count actual=%0d expected=%0d", tag, cnt, nexp);
      return;
    end
    for (int i = 0; i < nexp; i++) begin
      if (got[(base + i) % 1024] != expb[i]) begin
        fails++;
        $display("FAIL %s byte %0d actual=%02h expected=%02h", tag, i,
                 got[(base + i) % 1024], expb[i]);
        return;
      end
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [7:0] f, input logic [3:0] nw, input int c, input int l);
    @(posedge clk); #5;
    flags = f; newest = nw; scnt = 5'(c); wlim = 16'(l); start = 1'b1;
    @(posedge clk); #5;
    start = 1'b0;
  endtask

  task automatic wait_done(input int bd, input string tag);
    int t = 0;
    while (ndone == bd && t < 3000) begin @(posedge clk); t++; end
    if (ndone == bd) begin
      checks++; fails++;
      $display("FAIL %s no done pulse actual=0 expected=1", tag);
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic run_case(input logic [7:0] f, input logic [3:0] nw, input int c,
                          input int l, input string tag);
    int base, bd;
    model(f, nw, c, l);
    base = ng; bd = ndone;
    launch(f, nw, c, l);
    wait_done(bd, tag);
    check_stream(base, tag);
    check_int(ndone - bd, 1, {tag, " done pulses R10"});
  endtask

  task automatic put(input logic [3:0] nw, input int k, input logic [31:0] v);
    mem[4'(int'(nw) - k)] = v;
  endtask

  task automatic t_reset;
    @(negedge clk);
    checks++;
    if (ob_valid !== 1'b0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state actual=%b%b expected=00", ob_valid, done);
    end
  endtask

  task automatic t_plain;
    for (int i = 0; i < 16; i++) mem[i] = 32'h8000_0000 | (32'(i) * 32'h0102_0304) | 32'h0080_8080;
    run_case(8'h00, 4'd6, 5, 100, "R3 R4 plain newest-first");
  endtask

  task automatic t_groups;
    run_case(8'b0001_0100, 4'd9, 4, 100, "R2 groups 0,2 disabled");
    run_case(8'b0010_1000, 4'd12, 3, 100, "R2 groups 1,3 disabled");
  endtask

  task automatic t_wrap;
    run_case(8'h00, 4'd1, 4, 100, "R3 address wrap");
  endtask

  task automatic t_rle;
    put(4'd15, 0, 32'hC1A2_B3F4); put(4'd15, 1, 32'hC1A2_B3F4); put(4'd15, 2, 32'hC1A2_B3F4);
    put(4'd15, 3, 32'h1111_2222); put(4'd15, 4, 32'hFF00_0001); put(4'd15, 5, 32'hFF00_0001);
    run_case(8'h01, 4'd15, 6, 100, "R5 R6 run-length mixed runs");
  endtask

  task automatic t_sat;
    for (int k = 0; k < 7; k++) put(4'd10, k, 32'h8765_4321);
    put(4'd10, 7, 32'h0000_00AA);
    run_case(8'h01, 4'd10, 8, 100, "R7 count saturation split");
  endtask

  task automatic t_one_group;
    put(4'd5, 0, 32'h1234_56FF); put(4'd5, 1, 32'hABCD_EFFF); put(4'd5, 2, 32'h0000_0085);
    run_case(8'b0011_1001, 4'd5, 3, 100, "R6 R7 single group run-length");
  endtask

  task automatic t_masked_eq;
    put(4'd3, 0, 32'h0011_2233); put(4'd3, 1, 32'h9911_2233); put(4'd3, 2, 32'h7711_2233);
    run_case(8'b0010_0001, 4'd3, 3, 100, "R5 run matched on enabled groups only");
  endtask

  task automatic t_limit;
    for (int i = 0; i < 16; i++) mem[i] = 32'hA5A5_0000 | 32'(i);
    run_case(8'h00, 4'd8, 5, 2, "R8 word limit plain");
    for (int k = 0; k < 4; k++) put(4'd8, k, 32'h0F0F_0F0F);
    run_case(8'h01, 4'd8, 4, 1, "R8 word limit stops after count");
  endtask

  task automatic t_empty;
    run_case(8'h3C, 4'd4, 4, 100, "R11 all groups disabled");
    run_case(8'h00, 4'd4, 0, 100, "R11 zero samples");
    run_case(8'h01, 4'd4, 4, 0, "R11 zero word limit");
  endtask

  task automatic t_backpressure;
    int h0, b0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h3C00_0000 + 32'(i) * 32'h0001_0203;
    rmode = 1;
    h0 = holds; b0 = hold_bad;
    run_case(8'h00, 4'd14, 8, 100, "R9 backpressure stream");
    put(4'd14, 1, mem[14]); put(4'd14, 2, mem[14]);
    run_case(8'h01, 4'd14, 6, 100, "R9 backpressure run-length");
    rmode = 0;
    check_int(hold_bad - b0, 0, "R9 byte held while not ready");
    checks++;
    if (holds - h0 == 0) begin
      fails++;
      $display("FAIL R9 stall cycles actual=0 expected>0");
    end
  endtask

  task automatic t_busy;
    int base, bd;
    for (int i = 0; i < 16; i++) mem[i] = 32'h5A00_0000 | (32'(i) << 8) | 32'(i);
    model(8'h00, 4'd7, 6, 100);
    base = ng; bd = ndone;
    launch(8'h00, 4'd7, 6, 100);
    repeat (5) @(posedge clk);
    launch(8'h3D, 4'd2, 3, 1);
    wait_done(bd, "R10 start while busy");
    repeat (20) @(posedge clk);
    check_stream(base, "R10 start while busy ignored");
    check_int(ndone - bd, 1, "R10 single done with ignored start");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    #5 rst_n = 1'b1;
    t_reset();
    t_plain();
    t_groups();
    t_wrap();
    t_rle();
    t_sat();
    t_one_group();
    t_masked_eq();
    t_limit();
    t_empty();
    t_backpressure();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule